// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical stages of `WIDTH` bits each. All state bits of all stages change together on the rising clock edge. A parallel preset input loads an arbitrary value. An active-low clear zeroes the count. Two count-enable inputs gate counting: a "parallel" enable that only gates counting, and a "trickle" enable that gates both counting and the carry output.

Inside the wrapper, each stage's carry output drives the trickle enable of the next stage. The chain therefore behaves as a single counter of `STAGES*WIDTH` bits with no extra gating. The parallel enable is shared by every stage.

A parameter selects whether clear acts asynchronously or on the next clock edge. A second parameter, `MODULUS`, shortens the count cycle. When it is non-zero, the decoded terminal value `MODULUS-1` is fed back into an internal synchronous clear, so the counter cycles through 0 to `MODULUS-1`.

Top module: `cnt_chain`

## Requirements
- R1: Every state bit changes only at a rising clock edge (except on an asynchronous clear). A change of `load_n`, `din`, `cnt_en_p` or `cnt_en_t` between edges leaves `cnt` unchanged until the next edge.
- R2: With `clear_n` high and `load_n` low, the next rising edge copies `din` to `cnt`, whatever the enables are.
- R3: With `clear_n` and `load_n` high, `cnt` rises by one at the edge when `cnt_en_p` and `cnt_en_t` are both 1. If either enable is 0, `cnt` holds.
- R4: Counting from all ones gives all zeros (modulo 2^(STAGES*WIDTH)).
- R5: `carry_out` is 1 exactly when `cnt` is all ones and `cnt_en_t` is 1. It is combinational, and `cnt_en_p` has no effect on it.
- R6: With `CLR_MODE` = `CLR_SYNC`, `clear_n` low zeroes `cnt` at the next rising edge, not before.
- R7: With `CLR_MODE` = `CLR_ASYNC`, `clear_n` low zeroes `cnt` at once, without a clock edge.
- R8: Stage k+1 counts only when the lower stages are all ones and `cnt_en_t` is 1. For example, with 4-bit stages, 0x0F counts to 0x10, and 0xEF does not raise `carry_out`.
- R9: With `MODULUS` non-zero, counting from `MODULUS-1` gives 0 at the next edge. A load may still place any value, and from a value other than `MODULUS-1` counting is plain binary.
- R10: Priority at an edge is clear, then load, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Active-low clear (sync or async by `CLR_MODE`) |
| load_n | input | 1 | Active-low parallel preset |
| cnt_en_p | input | 1 | Count enable shared by all stages; gates counting only |
| cnt_en_t | input | 1 | Count enable into the lowest stage; gates counting and carry |
| din | input | STAGES*WIDTH | Preset value |
| cnt | output | STAGES*WIDTH | Current count |
| carry_out | output | 1 | High when the count is all ones and `cnt_en_t` is high |

## Verification
The bench builds three copies from shared controls:
- `u0` is two 4-bit stages with synchronous clear. It exercises the carry from stage to stage (0x0F to 0x10, and 0xFF to 0x00).
- `u1` is a single 4-bit stage with asynchronous clear. It walks the preset-12-then-wrap sequence and shows the count zeroing between edges.
- `u2` is the two-stage synchronous version with `MODULUS` = 100. It brings the truncated wrap from 99 to 0 within reach.

Because `u0` and `u2` share the same controls, a mid-cycle clear separates the two clear modes in one step.

// File: rtl/cnt_pkg.sv
// Package: shared types for the cascadable counter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package cnt_pkg;

    // How the clear input acts on a stage.
    typedef enum logic {
        CLR_ASYNC = 1'b0,
        CLR_SYNC  = 1'b1
    } clr_mode_e;

endpackage

// File: rtl/cnt_next.sv
// Module: next-state logic of one counter stage.
// Applies the fixed priority zero > load > increment > hold.
// Assumes zero_n already merges every synchronous clear source.
module cnt_next #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] pre,
    input  logic             zero_n,
    input  logic             load_n,
    input  logic             adv,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Pick the value the stage takes at the next edge.
    always_comb begin
        if (!zero_n)      nxt = '0;
        else if (!load_n) nxt = pre;
        else if (adv)     nxt = cur + ONE;
        else              nxt = cur;
    end

endmodule

// File: rtl/cnt_carry.sv
// Module: carry decode of one stage.
// The output is high when the stage is full and its trickle enable is high.
// Assumes a purely combinational path from enable to carry is acceptable.
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t,
    output logic             cy
);

    // Full-stage detect gated by the trickle enable.
    always_comb cy = (&cur) & en_t;

endmodule

// File: rtl/cnt_stage.sv
// Module: one WIDTH-bit presettable counter stage.
// Clear is asynchronous or synchronous according to CLR_MODE.
// trunc_n is always a synchronous clear, ranked just below clear.
// Assumes en_t comes from the stage below (or from the chain input).
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             trunc_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] pre,
    output logic [WIDTH-1:0] cur,
    output logic             cy
);

    localparam bit SYNC_CLR = (CLR_MODE == CLR_SYNC);

    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] nxt;
    logic             zero_n;
    logic             adv;

    // Merge the synchronous clear sources and the count qualifier.
    always_comb begin
        zero_n = (SYNC_CLR ? clear_n : 1'b1) & trunc_n;
        adv    = en_p & en_t;
    end

    cnt_next #(.WIDTH(WIDTH)) u_next (
        .cur    (q_r),
        .pre    (pre),
        .zero_n (zero_n),
        .load_n (load_n),
        .adv    (adv),
        .nxt    (nxt)
    );

    generate
        if (SYNC_CLR) begin : g_sync
            // State register; clear enters through the next-state logic.
            always_ff @(posedge clk) q_r <= nxt;

            AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!clear_n)
                $past(!clear_n) |-> (q_r == '0)); // R6
        end else begin : g_async
            // State register with an asynchronous active-low clear.
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) q_r <= '0;
                else          q_r <= nxt;
            end

            AST_ASYNC_ZERO: assert property (@(negedge clk)
                !clear_n |-> (q_r == '0)); // R7
        end
    endgenerate

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .cur  (q_r),
        .en_t (en_t),
        .cy   (cy)
    );

    assign cur = q_r;

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clear_n)
        (!load_n && trunc_n) |=> (q_r == $past(pre))); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && trunc_n && !(en_p && en_t)) |=> $stable(q_r)); // R3
    AST_STEP: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && trunc_n && en_p && en_t) |=> (q_r == WIDTH'($past(q_r) + 1'b1))); // R4

endmodule

// File: rtl/cnt_chain.sv
// Module: top of the cascadable counter.
// STAGES identical stages are chained through their carries.
// The parallel enable is shared by all stages.
// An optional terminal-count feedback into synchronous clear shortens the cycle.
// Assumes MODULUS is 0 (full binary range) or between 2 and 2**(STAGES*WIDTH).
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter int        STAGES   = 2,
    parameter clr_mode_e CLR_MODE = CLR_SYNC,
    parameter int        MODULUS  = 0
) (
    input  logic                     clk,
    input  logic                     clear_n,
    input  logic                     load_n,
    input  logic                     cnt_en_p,
    input  logic                     cnt_en_t,
    input  logic [STAGES*WIDTH-1:0]  din,
    output logic [STAGES*WIDTH-1:0]  cnt,
    output logic                     carry_out
);

    localparam int TW    = STAGES * WIDTH;
    localparam bit TRUNC = (MODULUS != 0);

    logic [STAGES:0] t_chain;
    logic            trunc_n;

    // Lowest stage takes the external trickle enable.
    always_comb t_chain[0] = cnt_en_t;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            cnt_stage #(
                .WIDTH    (WIDTH),
                .CLR_MODE (CLR_MODE)
            ) u_stage (
                .clk     (clk),
                .clear_n (clear_n),
                .trunc_n (trunc_n),
                .load_n  (load_n),
                .en_p    (cnt_en_p),
                .en_t    (t_chain[k]),
                .pre     (din[k*WIDTH +: WIDTH]),
                .cur     (cnt[k*WIDTH +: WIDTH]),
                .cy      (t_chain[k+1])
            );
        end

        if (TRUNC) begin : g_trunc
            localparam logic [TW-1:0] LAST = TW'(MODULUS - 1);

            // Decode the terminal value on a counting edge that is not a load.
            always_comb trunc_n = !((cnt == LAST) && cnt_en_p && cnt_en_t && load_n);

            AST_TRUNC_WRAP: assert property (@(posedge clk) disable iff (!clear_n)
                ((cnt == LAST) && cnt_en_p && cnt_en_t && load_n) |=> (cnt == '0)); // R9
        end else begin : g_full
            // Full binary range: the terminal clear never fires.
            always_comb trunc_n = 1'b1;
        end
    endgenerate

    // Chain carry is the top stage's carry.
    always_comb carry_out = t_chain[STAGES];

    AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out |-> (cnt == {TW{1'b1}})); // R8
    AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clear_n)
        !cnt_en_t |-> !carry_out); // R5

endmodule

// File: tb/sim_cnt_chain.sv
// Bench: a vector table walked by one loop, then directed corner tests.
// u0: 2x4 bits, sync clear. u1: 1x4 bits, async clear. u2: 2x4 bits, sync, MODULUS=100.
module sim_cnt_chain;
    import cnt_pkg::*;

    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       load_n = 1'b1;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] q0, q2;
    logic [3:0] q1;
    logic       c0, c1, c2;
    int         total = 0;
    int         bad = 0;

    always #4 clk = ~clk;

    cnt_chain #(.WIDTH(4), .STAGES(2), .CLR_MODE(CLR_SYNC), .MODULUS(0)) u0 (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en_p(en_p),
        .cnt_en_t(en_t), .din(din), .cnt(q0), .carry_out(c0));
    cnt_chain #(.WIDTH(4), .STAGES(1), .CLR_MODE(CLR_ASYNC), .MODULUS(0)) u1 (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en_p(en_p),
        .cnt_en_t(en_t), .din(din[3:0]), .cnt(q1), .carry_out(c1));
    cnt_chain #(.WIDTH(4), .STAGES(2), .CLR_MODE(CLR_SYNC), .MODULUS(100)) u2 (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en_p(en_p),
        .cnt_en_t(en_t), .din(din), .cnt(q2), .carry_out(c2));

    typedef struct packed {
        logic       clr;
        logic       ld;
        logic       p;
        logic       t;
        logic [7:0] d;
        logic [7:0] e8;
        logic [3:0] e4;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 4'h0},  // clear state: R6 R7
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h0C, 8'h0C, 4'hC},  // load, enables low: R2
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h0D, 4'hD},  // count: R3
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h0E, 4'hE},  // R3
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 4'hF},  // R3
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 4'h0},  // stage carry / wrap: R8 R4
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h11, 4'h1},  // R3
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h12, 4'h2},  // R3
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h12, 4'h2},  // P low holds: R3
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h12, 4'h2},  // T low holds: R3
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 8'h00, 4'h0},  // clear beats load: R10
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 8'hA5, 4'h5}   // load beats count: R10
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic l, input logic p,
                         input logic t, input logic [7:0] d);
        @(negedge clk);
        clear_n = c; load_n = l; en_p = p; en_t = t; din = d;
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        // Table walk: reset state, presets, counting, holds, priority.
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].clr, TBL[i].ld, TBL[i].p, TBL[i].t, TBL[i].d);
            edge_wait();
            chk(q0 == TBL[i].e8, $sformatf("R3 table row %0d u0", i), q0, TBL[i].e8);
            chk(q1 == TBL[i].e4, $sformatf("R3 table row %0d u1", i), q1, TBL[i].e4);
            chk(q2 == TBL[i].e8, $sformatf("R3 table row %0d u2", i), q2, TBL[i].e8);
        end

        // R5: full count with T high raises carry, P low does not matter.
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
        edge_wait();
        chk(c0 == 1'b1, "R5 carry u0 full, P low", c0, 1);
        chk(c1 == 1'b1, "R5 carry u1 full, P low", c1, 1);
        // R5: dropping T between edges clears carry combinationally.
        en_t = 1'b0;
        #1;
        chk(c0 == 1'b0, "R5 carry u0 with T low", c0, 0);
        chk(c1 == 1'b0, "R5 carry u1 with T low", c1, 0);

        // R8: lower stage full, upper not -> no chain carry.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hEF);
        edge_wait();
        chk(c0 == 1'b0, "R8 no carry at EF", c0, 0);
        chk(c1 == 1'b1, "R5 single stage carry at F", c1, 1);

        // R4: wrap of the full chain from all ones.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF);
        edge_wait();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        edge_wait();
        chk(q0 == 8'h00, "R4 u0 wrap FF->00", q0, 8'h00);
        chk(q1 == 4'h0, "R4 u1 wrap F->0", q1, 4'h0);
        chk(q2 == 8'h00, "R9 u2 plain count beyond modulus", q2, 8'h00);

        // R9: truncated wrap 98 -> 99 -> 0, while u0 goes on to 100.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'd98);
        edge_wait();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        edge_wait();
        chk(q2 == 8'd99, "R9 u2 reaches 99", q2, 99);
        edge_wait();
        chk(q2 == 8'd0, "R9 u2 wraps 99->0", q2, 0);
        chk(q0 == 8'd100, "R3 u0 counts to 100", q0, 100);

        // R1: a load set up between edges waits for the edge.
        @(negedge clk);
        load_n = 1'b0; en_p = 1'b0; din = 8'h33;
        #1;
        chk(q0 == 8'd100, "R1 u0 unchanged before edge", q0, 100);
        chk(q1 == 4'h4, "R1 u1 unchanged before edge", q1, 4'h4);
        edge_wait();
        chk(q0 == 8'h33, "R2 u0 loaded at edge", q0, 8'h33);

        // R7 vs R6: clear mid-cycle zeroes the async copy at once only.
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        edge_wait();
        chk(q0 == 8'h34, "R3 u0 at 34", q0, 8'h34);
        clear_n = 1'b0;
        #1;
        chk(q1 == 4'h0, "R7 async clear without edge", q1, 4'h0);
        chk(q0 == 8'h34, "R6 sync clear waits for edge", q0, 8'h34);
        edge_wait();
        chk(q0 == 8'h00, "R6 sync clear at edge", q0, 8'h00);
        chk(q2 == 8'h00, "R6 u2 sync clear at edge", q2, 8'h00);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        edge_wait();

        finish_run();
    end

endmodule